// File: doc/BRIEF.md
# Multi-Hart Debug Halt and Resume Controller

This block is the run-control part of a debug unit. An external debug transport reaches it through a simple 32-bit register bus. Through this bus the debugger picks one hart by index, asks it to halt or resume, and reads back whether that hart has halted or has acknowledged the resume. The block drives one halt-request line and one resume-request line to each hart. It receives a halted flag and a running flag back from each hart.

A control word holds the hart index, a level-sensitive halt request, a one-shot resume request, a system-reset request and an enable bit. The debugger must set the enable bit before anything else takes effect. The enable bit is also brought out so that power management can keep the debug logic powered. The system-reset request drives an output only. The block's own registers are cleared only by its local reset, so they keep their values across a system reset that the block itself requested. Summary words report the halted flag of every hart, 32 harts per word, so the debugger can find halted harts without selecting each one.

Top module: `dbg_hart_ctl`

## Requirements
- R1: After the local reset, the control word (address 0x10) reads 0. All halt and resume request lines, `sys_reset_o` and `dm_active_o` are 0. A read issued in one cycle returns `bus_rdata` with `bus_rvalid` high in the next cycle.
- R2: Control bit 0 is the enable bit. A control write with bit 0 clear stores all zeros, so every other field written with it reads back 0. One cycle after the enable bit is cleared, every request line is 0 and every resume acknowledge is cleared.
- R3: Control bit 31 is the halt request, and bits 25:16 are the hart index. While bit 31 is set, `halt_req_o[index]` is high from the second cycle after the write, and no other halt line is high. The line falls once the bit is written back to 0.
- R4: Bit 0 of the status word (address 0x11) reads 1 exactly when the selected hart reports halted.
- R5: A control write with bit 30 set (and bit 31 clear) to a hart that is not running does three things: it clears that hart's acknowledge, which is status bit 1; it raises `resume_req_o` for that hart; and it holds the line until the hart reports running. At that point the line drops and the acknowledge sets. The acknowledge then stays set after the hart stops running, until the next resume request to that hart.
- R6: A resume request to a hart that already reports running sets its acknowledge at once and raises no resume line.
- R7: When bits 31 and 30 are both set in one write, the halt request is taken and the resume request is discarded.
- R8: When the hart index is NUM_HARTS or higher, status bit 2 reads 1 and status bits 0 and 1 read 0. Halt and resume requests to that index raise no line.
- R9: Control bit 1 drives `sys_reset_o`. While that bit is set, the control word keeps its value.
- R10: The summary word at address 0x40+g holds the halted flags of harts 32g to 32g+31 in bit order. Bits for harts that are not implemented read 0.
- R11: `dm_active_o` follows the stored enable bit, and control bit 30 always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Local synchronous active-high reset of the debug logic |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| hart_halted_i | input | NUM_HARTS | Per-hart halted flag |
| hart_running_i | input | NUM_HARTS | Per-hart running flag |
| halt_req_o | output | NUM_HARTS | Per-hart halt request |
| resume_req_o | output | NUM_HARTS | Per-hart resume request |
| sys_reset_o | output | 1 | Reset request to the rest of the system |
| dm_active_o | output | 1 | Debug logic enabled |

## Verification
The hardest state to reach is the sticky acknowledge. It has to be observed after the hart has stopped running again, and it has to be shown to clear only when a new resume request arrives. The bench first resumes a stopped hart and raises its running flag. It then drops that flag again, reads status, and only afterwards issues a second resume request. A random phase then moves the hart index across the implemented range and beyond it, with random halted patterns. While it runs, the acknowledges left by the directed phase must stay unchanged and must be reported only for the hart that owns them.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned SEL_W   = 10;
  localparam int unsigned A_CTRL  = 'h10;
  localparam int unsigned A_STAT  = 'h11;
  localparam int unsigned A_SUM   = 'h40;
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_SRST  = 1;
  localparam int unsigned B_SEL   = 16;
  localparam int unsigned B_RES   = 30;
  localparam int unsigned B_HALT  = 31;

  typedef struct packed {
    logic             halt;
    logic [SEL_W-1:0] sel;
    logic             srst;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output ctrl_t             ctrl_q,
  output logic              res_wr,
  output logic [SEL_W-1:0]  res_sel
);
  logic wr_ctrl;

  assign wr_ctrl = bus_req && bus_we && (bus_addr == ADDR_W'(A_CTRL));

  // resume strobe only when already enabled and halt not requested together
  assign res_wr  = wr_ctrl && ctrl_q.en && bus_wdata[B_EN]
                   && bus_wdata[B_RES] && !bus_wdata[B_HALT];
  assign res_sel = bus_wdata[B_SEL +: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      if (bus_wdata[B_EN]) begin
        ctrl_q.en   <= 1'b1;
        ctrl_q.srst <= bus_wdata[B_SRST];
        ctrl_q.sel  <= bus_wdata[B_SEL +: SEL_W];
        ctrl_q.halt <= bus_wdata[B_HALT];
      end else begin
        ctrl_q <= '0;
      end
    end
  end
endmodule

// File: rtl/dbg_hart_lane.sv
module dbg_hart_lane
  import dbg_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             halt_bit,
  input  logic             res_wr,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             running,
  output logic             halt_o,
  output logic             resume_o,
  output logic             ack_o
);
  localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(IDX);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      halt_o   <= 1'b0;
      resume_o <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      halt_o <= halt_bit && (sel == MY_IDX);
      if (res_wr && (res_sel == MY_IDX)) begin
        if (running) begin
          ack_o    <= 1'b1;
          resume_o <= 1'b0;
        end else begin
          ack_o    <= 1'b0;
          resume_o <= 1'b1;
        end
      end else if (resume_o && running) begin
        resume_o <= 1'b0;
        ack_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_status_view.sv
module dbg_status_view
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 40,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  ctrl_t                ctrl_q,
  input  logic [NUM_HARTS-1:0] halted_i,
  input  logic [NUM_HARTS-1:0] ack_i,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 bus_rvalid
);
  localparam int unsigned GROUPS = (NUM_HARTS + REG_W - 1) / REG_W;
  localparam int unsigned PAD_W  = GROUPS * REG_W;

  logic [NUM_HARTS-1:0] halted_q;
  logic [PAD_W-1:0]     sum_pad;
  logic                 sel_ok, sel_halted, sel_ack;
  logic [REG_W-1:0]     rd_next;
  logic [ADDR_W-1:0]    grp_off;

  always_ff @(posedge clk) begin
    if (rst || !ctrl_q.en) halted_q <= '0;
    else                   halted_q <= halted_i;
  end

  assign sum_pad = PAD_W'(halted_q);
  assign sel_ok  = (32'(ctrl_q.sel) < NUM_HARTS);
  assign grp_off = bus_addr - ADDR_W'(A_SUM);

  always_comb begin
    sel_halted = 1'b0;
    sel_ack    = 1'b0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (ctrl_q.sel == SEL_W'(h)) begin
        sel_halted = halted_q[h];
        sel_ack    = ack_i[h];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      rd_next[B_EN]            = ctrl_q.en;
      rd_next[B_SRST]          = ctrl_q.srst;
      rd_next[B_SEL +: SEL_W]  = ctrl_q.sel;
      rd_next[B_HALT]          = ctrl_q.halt;
    end else if (bus_addr == ADDR_W'(A_STAT)) begin
      rd_next[0] = sel_ok && sel_halted;
      rd_next[1] = sel_ok && sel_ack;
      rd_next[2] = !sel_ok;
    end else if (bus_addr >= ADDR_W'(A_SUM) && 32'(grp_off) < GROUPS) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_off == ADDR_W'(g)) rd_next = sum_pad[g*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/dbg_hart_ctl.sv
module dbg_hart_ctl
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 40,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_HARTS-1:0] hart_halted_i,
  input  logic [NUM_HARTS-1:0] hart_running_i,
  output logic [NUM_HARTS-1:0] halt_req_o,
  output logic [NUM_HARTS-1:0] resume_req_o,
  output logic                 sys_reset_o,
  output logic                 dm_active_o
);
  ctrl_t                ctrl_q;
  logic                 res_wr;
  logic [SEL_W-1:0]     res_sel;
  logic [NUM_HARTS-1:0] ack;

  dbg_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl_q(ctrl_q), .res_wr(res_wr), .res_sel(res_sel)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_lane
    dbg_hart_lane #(.IDX(h)) u_lane (
      .clk(clk), .rst(rst), .en(ctrl_q.en), .sel(ctrl_q.sel),
      .halt_bit(ctrl_q.halt), .res_wr(res_wr), .res_sel(res_sel),
      .running(hart_running_i[h]),
      .halt_o(halt_req_o[h]), .resume_o(resume_req_o[h]), .ack_o(ack[h])
    );
  end

  dbg_status_view #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_view (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .ctrl_q(ctrl_q), .halted_i(hart_halted_i),
    .ack_i(ack), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  assign sys_reset_o = ctrl_q.srst;
  assign dm_active_o = ctrl_q.en;
endmodule

// File: rtl/dbg_hart_ctl_chk.sv
module dbg_hart_ctl_chk #(
  parameter int unsigned NUM_HARTS = 40,
  parameter int unsigned ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_rvalid,
  input logic [NUM_HARTS-1:0] hart_running_i,
  input logic [NUM_HARTS-1:0] halt_req_o,
  input logic [NUM_HARTS-1:0] resume_req_o,
  input logic                 dm_active_o
);
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r3_single_halt: assert property (@(posedge clk) disable iff (rst)
    $onehot0(halt_req_o));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dm_active_o |=> (halt_req_o == '0 && resume_req_o == '0));

  a_r5_resume_drops: assert property (@(posedge clk) disable iff (rst)
    ((resume_req_o & hart_running_i) != '0)
      |=> ((resume_req_o & $past(resume_req_o & hart_running_i)) == '0));

  a_r7_halt_wins: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == ADDR_W'('h10) && bus_wdata[31] && bus_wdata[30])
      |=> ((resume_req_o & ~$past(resume_req_o)) == '0));
endmodule

bind dbg_hart_ctl dbg_hart_ctl_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .hart_running_i(hart_running_i),
  .halt_req_o(halt_req_o), .resume_req_o(resume_req_o), .dm_active_o(dm_active_o)
);

// File: tb/test_dbg_hart_ctl.sv
module test_dbg_hart_ctl;
  localparam int N = 40;
  localparam logic [6:0] CTRL = 7'h10, STAT = 7'h11, SUM = 7'h40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  hart_halted_i = '0, hart_running_i = '0;
  logic [N-1:0]  halt_req_o, resume_req_o;
  logic          sys_reset_o, dm_active_o;

  int checks = 0, errors = 0;
  logic [N-1:0] m_ack = '0;

  always #2 clk = ~clk;

  dbg_hart_ctl #(.NUM_HARTS(N), .ADDR_W(7)) i_dbg_hart_ctl (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit halt, bit res, int sel, bit srst);
    return {halt, res, 4'b0, 10'(sel), 14'b0, srst, 1'b1};
  endfunction

  function automatic logic [31:0] exp_status(int sel, logic [N-1:0] hv, logic [N-1:0] ak);
    if (sel >= N) return 32'h4;
    return {29'b0, 1'b0, ak[sel], hv[sel]};
  endfunction

  function automatic logic [N-1:0] one_hot(int sel);
    return (sel < N) ? (N'(1) << sel) : '0;
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0;
    chk("R1 rvalid", 64'(bus_rvalid), 64'd1);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] hv;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(CTRL, d);
    chk("R1 ctrl", 64'(d), 64'd0);
    chk("R1 outs", {halt_req_o, resume_req_o, sys_reset_o, dm_active_o}, '0);

    // R11 enable and resume bit readback
    wr(CTRL, ctrl_word(0, 0, 2, 0));
    chk("R11 active", 64'(dm_active_o), 64'd1);

    // R5 resume a stopped hart
    wr(CTRL, ctrl_word(0, 1, 3, 0));
    settle();
    chk("R5 req up", 64'(resume_req_o), 64'(one_hot(3)));
    rd(CTRL, d);
    chk("R11 res reads 0", 64'(d), 64'(ctrl_word(0, 0, 3, 0)));
    rd(STAT, d);
    chk("R5 ack low", 64'(d), 64'(exp_status(3, '0, '0)));
    @(negedge clk) hart_running_i[3] = 1;
    settle();
    chk("R5 req drop", 64'(resume_req_o), 64'd0);
    @(negedge clk) hart_running_i[3] = 0;
    m_ack[3] = 1;
    rd(STAT, d);
    chk("R5 ack sticky", 64'(d), 64'(exp_status(3, '0, m_ack)));
    wr(CTRL, ctrl_word(0, 1, 3, 0));
    m_ack[3] = 0;
    rd(STAT, d);
    chk("R5 ack clears on new req", 64'(d), 64'(exp_status(3, '0, m_ack)));
    chk("R5 req again", 64'(resume_req_o), 64'(one_hot(3)));
    @(negedge clk) hart_running_i[3] = 1;
    settle();
    m_ack[3] = 1;
    @(negedge clk) hart_running_i[3] = 0;

    // R6 already running
    @(negedge clk) hart_running_i[5] = 1;
    wr(CTRL, ctrl_word(0, 1, 5, 0));
    settle();
    chk("R6 no req", 64'(resume_req_o), 64'd0);
    m_ack[5] = 1;
    rd(STAT, d);
    chk("R6 ack now", 64'(d), 64'(exp_status(5, '0, m_ack)));
    @(negedge clk) hart_running_i[5] = 0;

    // R7 halt wins
    wr(CTRL, ctrl_word(1, 1, 7, 0));
    settle();
    chk("R7 halt", 64'(halt_req_o), 64'(one_hot(7)));
    chk("R7 no resume", 64'(resume_req_o), 64'd0);

    // R8 nonexistent target
    wr(CTRL, ctrl_word(0, 1, 45, 0));
    settle();
    chk("R8 no resume", 64'(resume_req_o), 64'd0);
    rd(STAT, d);
    chk("R8 status", 64'(d), 64'h4);

    // R9 system reset keeps state
    wr(CTRL, ctrl_word(1, 0, 9, 1));
    settle();
    chk("R9 srst out", 64'(sys_reset_o), 64'd1);
    rd(CTRL, d);
    chk("R9 ctrl kept", 64'(d), 64'(ctrl_word(1, 0, 9, 1)));
    chk("R3 halt under srst", 64'(halt_req_o), 64'(one_hot(9)));
    wr(CTRL, ctrl_word(0, 0, 9, 0));
    settle();
    chk("R3 halt falls", 64'(halt_req_o), 64'd0);
    chk("R9 srst falls", 64'(sys_reset_o), 64'd0);

    // random halt / status / summary
    for (int it = 0; it < 60; it++) begin
      int sel;
      int grp;
      hv = {$urandom, $urandom} & {24'b0, {N{1'b1}}};
      sel = int'($urandom_range(0, 47));
      grp = int'($urandom_range(0, 1));
      @(negedge clk) hart_halted_i = hv[N-1:0];
      wr(CTRL, ctrl_word(1, 0, sel, 0));
      settle();
      chk("R3/R8 halt lines", 64'(halt_req_o), 64'(one_hot(sel)));
      rd(STAT, d);
      chk("R4/R8 status", 64'(d), 64'(exp_status(sel, hv[N-1:0], m_ack)));
      rd(SUM + 7'(grp), d);
      chk("R10 summary", 64'(d), 64'(hv[grp*32 +: 32]));
    end

    // R2 disable clears and blocks
    wr(CTRL, 32'h800A_0002);
    settle();
    rd(CTRL, d);
    chk("R2 ctrl zero", 64'(d), 64'd0);
    chk("R2 lines", {halt_req_o, resume_req_o, dm_active_o}, '0);
    wr(CTRL, ctrl_word(0, 0, 3, 0));
    rd(STAT, d);
    chk("R2 ack cleared", 64'(d), 64'(exp_status(3, hart_halted_i, '0)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule